// File: doc/BRIEF.md
# Supply-Fail Write Lockout Sequencer

This block sits between a memory's raw bus strobes and its array. A digital supply-low flag, produced by a voltage comparator elsewhere, tells it when the supply is below the fail threshold. While that flag is active, the sequencer closes a gate. No select, write or read reaches the array, and the data outputs lose permission to drive, so they float. Stored contents are untouched for the whole time the gate is closed, including a total loss of supply.

Lockout starts a bounded number of cycles after the flag rises, because the flag is resynchronized first. A write already in flight is cut off at that moment, not allowed to finish. When the flag clears, the gate stays shut for a long, parameterised recovery interval. Any new sighting of the flag during that interval sends the block back to lockout, and the full interval is then counted again. Reset leaves the block locked.

Top module: `supply_lockout_seq`

## Requirements
- R1: While reset is held, and on leaving it, the gate is closed: `locked`=1 and `sel_out`, `wr_out`, `rd_ok` are 0 whatever the strobe inputs are.
- R2: While the gate is closed, `sel_out`, `wr_out` and `rd_ok` are 0 for all eight combinations of `sel_in`, `wr_in`, `rd_in`.
- R3: When `supply_low` is first sampled high at rising edge k, the gate is still open after edge k and is closed after edge k+1.
- R4: A write held active (`sel_in`=`wr_in`=1) when the supply fails is cut off: `wr_out` falls after edge k+1 even though `wr_in` stays 1.
- R5: When `supply_low` is first sampled low at edge k while locked, the gate remains closed after each of edges k through k+RECOVER_CYC+1. It opens after edge k+RECOVER_CYC+2.
- R6: A high sample of `supply_low` at any point of the recovery interval returns the block to lockout. The full R5 interval then restarts from the next low sample, including a sighting in the last cycles before the gate would have opened.
- R7: While the gate is open, `sel_out`=`sel_in`, `wr_out`=`sel_in`&`wr_in`, and `rd_ok`=`sel_in`&`rd_in`&!`wr_in`. A write takes precedence over output drive.
- R8: `locked` is 1 exactly when the gate is closed. It is 0 only in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low | input | 1 | Supply below fail threshold (asynchronous) |
| sel_in | input | 1 | Raw chip select, active high |
| wr_in | input | 1 | Raw write strobe, active high |
| rd_in | input | 1 | Raw output enable, active high |
| sel_out | output | 1 | Gated select to the array |
| wr_out | output | 1 | Gated write strobe to the array |
| rd_ok | output | 1 | Permission for the data outputs to drive |
| locked | output | 1 | Gate closed |

## Verification
The strobe gating is combinational, so in a steady state the outputs are checked one time step after the inputs change, with no clock edge between. Lockout is due after the second rising edge that sees the supply flag high. Release is due after edge RECOVER_CYC+2, counted from the first edge that sees the flag low. The bench drives each input just after an edge. It then samples after every single edge across those windows, so both the last closed cycle and the first open cycle are checked. The restart case places the flag in the final cycles of recovery, where a counter that ran one cycle late would open the gate early.

// File: rtl/supply_lockout_seq.sv
module supply_lockout_seq #(
  parameter int RECOVER_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic sel_in,
  input  logic wr_in,
  input  logic rd_in,
  output logic sel_out,
  output logic wr_out,
  output logic rd_ok,
  output logic locked
);
  localparam int CNT_W = (RECOVER_CYC > 2) ? $clog2(RECOVER_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOVER_CYC - 1);

  typedef enum logic [1:0] {ST_LOCK, ST_RECOVER, ST_RUN} st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]      sync_q;
  logic            fail_s;
  logic            gate_open;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], supply_low};

  assign fail_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_LOCK;
      cnt <= '0;
    end else begin
      case (st)
        ST_LOCK:
          if (!fail_s) begin
            st  <= ST_RECOVER;
            cnt <= '0;
          end
        ST_RECOVER:
          if (fail_s)           st  <= ST_LOCK;
          else if (cnt == LAST) st  <= ST_RUN;
          else                  cnt <= cnt + 1'b1;
        ST_RUN:
          if (fail_s) st <= ST_LOCK;
        default: st <= ST_LOCK;
      endcase
    end
  end

  assign gate_open = (st == ST_RUN) && !fail_s;
  assign sel_out   = gate_open & sel_in;
  assign wr_out    = gate_open & sel_in & wr_in;
  assign rd_ok     = gate_open & sel_in & rd_in & ~wr_in;
  assign locked    = ~gate_open;

  assert_lockout_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> ##2 (!sel_out && !wr_out && !rd_ok));

  assert_release_after_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && $past(st) != ST_RUN) |-> ($past(st) == ST_RECOVER && $past(cnt) == LAST));

  assert_restart_on_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECOVER && fail_s) |=> (st == ST_LOCK));

  assert_write_beats_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |-> (sel_out && !rd_ok));

  assert_locked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!sel_out && !wr_out && !rd_ok));
endmodule

// File: tb/supply_lockout_seq_test.sv
module supply_lockout_seq_test;
  localparam int RC = 12;

  logic clk = 1'b0;
  logic rst_n, supply_low, sel_in, wr_in, rd_in;
  logic sel_out, wr_out, rd_ok, locked;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  supply_lockout_seq #(.RECOVER_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
    .sel_in(sel_in), .wr_in(wr_in), .rd_in(rd_in),
    .sel_out(sel_out), .wr_out(wr_out), .rd_ok(rd_ok), .locked(locked));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_out(input string req, input logic es, input logic ew,
                            input logic er, input logic el);
    checks++;
    if ({sel_out, wr_out, rd_ok, locked} !== {es, ew, er, el}) begin
      fails++;
      $display("FAIL %s: sel/wr/rd/locked actual %b%b%b%b expected %b%b%b%b",
               req, sel_out, wr_out, rd_ok, locked, es, ew, er, el);
    end
  endtask

  task automatic expect_closed(input string req);
    expect_out(req, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic set_strobes(input logic [2:0] v);
    {sel_in, wr_in, rd_in} = v;
    #1;
  endtask

  task automatic check_recovery(input string req);
    for (int j = 0; j <= RC + 1; j++) begin
      step(1);
      expect_closed(req);
    end
    step(1);
    expect_out(req, sel_in, sel_in & wr_in, sel_in & rd_in & ~wr_in, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; supply_low = 1'b0;
    sel_in = 1'b1; wr_in = 1'b0; rd_in = 1'b1;
    #21;
    expect_closed("R1 in reset");
    @(posedge clk); #2;
    rst_n = 1'b1;
    expect_closed("R1 after reset");
    check_recovery("R5 first release");

    for (int v = 0; v < 8; v++) begin
      set_strobes(3'(v));
      expect_out("R7 open sweep", v[2], v[2] & v[1], v[2] & v[0] & ~v[1], 1'b0);
    end

    set_strobes(3'b110);
    supply_low = 1'b1;
    step(1);
    expect_out("R3 still open one edge after", 1'b1, 1'b1, 1'b0, 1'b0);
    step(1);
    expect_closed("R4 write cut off");
    expect_closed("R3 closed two edges after");

    for (int v = 0; v < 8; v++) begin
      set_strobes(3'(v));
      expect_closed("R2 locked sweep");
      expect_closed("R8 locked flag");
    end
    step(5);
    expect_closed("R2 locked hold");

    set_strobes(3'b101);
    supply_low = 1'b0;
    check_recovery("R5 second release");

    supply_low = 1'b1;
    step(3);
    expect_closed("R8 lock again");
    supply_low = 1'b0;
    step(RC);
    expect_closed("R6 mid recovery");
    supply_low = 1'b1;
    step(1);
    supply_low = 1'b0;
    check_recovery("R6 late restart");

    supply_low = 1'b1;
    step(2);
    supply_low = 1'b0;
    step(3);
    supply_low = 1'b1;
    step(1);
    supply_low = 1'b0;
    check_recovery("R6 early restart");

    set_strobes(3'b111);
    expect_out("R7 write over read", 1'b1, 1'b1, 1'b0, 1'b0);
    finish_run();
  end
endmodule